// File: doc/BRIEF.md
# Auto-Increment Register File with Time Snapshot

This block is the byte store behind a serial-bus slave in a timekeeping device. It has 64 byte locations. The first eight hold the time, calendar and control bytes. The other 56 are general-purpose RAM. A six-bit pointer selects the location. The bus front end loads the pointer, and the pointer then moves forward by one after every acknowledged data byte. A burst of bytes therefore walks through the map and wraps from the last location back to the first.

The time bytes are never read straight from the running counters. A shadow buffer of eight bytes captures the live counter values on a bus START, on a bus STOP, and when the pointer wraps onto location 0. All eight bytes of a burst read then come from one instant, while the counters keep running.

A write to a time byte is passed to the counter logic through a one-cycle write strobe. The same write also updates the shadow entry, so a later read in the same transfer returns the value that was written. The bit-level bus protocol lives outside this block. It reaches the block as single-cycle strobes: start, stop, pointer load, write acknowledge and read acknowledge.

Top module: `rtc_regfile`

## Requirements
- R1: After a synchronous reset the pointer is 0, the shadow buffer holds all zeros, `rd_data` is 0 and `tk_we` is low.
- R2: A `ptr_load` pulse sets the pointer to `ptr_addr`. `rd_data` shows the byte at that location from the second rising edge after the load. A load takes priority over an acknowledge in the same cycle.
- R3: Each cycle with `wr_ack` or `rd_ack` high and no load advances the pointer by one, modulo 64. Location 0x3F is followed by 0x00.
- R4: The shadow buffer captures the masked `live_time` bytes on a `bus_start` pulse, on a `bus_stop` pulse, and on an acknowledge that moves the pointer from 0x3F to 0x00.
- R5: Reads at 0x00 to 0x07 return the shadow buffer. Changes on `live_time` after a capture do not appear in `rd_data` until the next capture.
- R6: A `wr_ack` at a pointer of 0x00 to 0x07 produces, one cycle later, a one-cycle `tk_we` pulse. `tk_addr` carries the pointer value and `tk_data` the masked write data. The shadow entry takes the masked value at the same edge.
- R7: Bits defined as zero read as 0 and are dropped on write. The kept-bit masks for locations 0 to 7 are 0xFF, 0x7F, 0x7F, 0x07, 0x3F, 0x1F, 0xFF and 0xB3.
- R8: Locations 0x08 to 0x3F store and return full 8-bit values, are not affected by captures, and never raise `tk_we`.
- R9: When a capture and a time-byte write happen in the same cycle, the written entry keeps the written value. All other entries take the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Bus START seen (one-cycle pulse) |
| bus_stop | input | 1 | Bus STOP seen (one-cycle pulse) |
| ptr_load | input | 1 | Load the pointer from `ptr_addr` |
| ptr_addr | input | 6 | Register address received from the bus |
| wr_ack | input | 1 | Write data byte acknowledged |
| wr_data | input | 8 | Write data byte |
| rd_ack | input | 1 | Read data byte acknowledged by the master |
| rd_data | output | 8 | Byte at the current pointer (registered) |
| live_time | input | 64 | Live counter bytes; byte i at bits 8i+7..8i |
| tk_we | output | 1 | Write strobe to the live counters |
| tk_addr | output | 3 | Index of the time byte being written |
| tk_data | output | 8 | Masked byte for the live counters |

## Verification
The bound checker watches these on every cycle:
- the pointer load and the modulo-64 advance;
- that `tk_we` only follows an acknowledged write inside the time window;
- that `tk_data` never carries a bit outside its mask;
- that a STOP with no write in the same cycle leaves the shadow equal to the masked live bytes.

Some behaviour shows only in the bench's directed scenarios, where a burst is read back after `live_time` has moved on:
- captures on START and on a wrap;
- RAM contents that are not affected by captures;
- write data winning over a capture in the same cycle.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
  localparam int TIME_BYTES = 8;
  localparam int RAM_BYTES  = 56;

  // Bits kept in each time/control location; all other bits are zero.
  function automatic logic [7:0] keep_mask(input int idx);
    case (idx)
      0:       keep_mask = 8'hFF;
      1:       keep_mask = 8'h7F;
      2:       keep_mask = 8'h7F;
      3:       keep_mask = 8'h07;
      4:       keep_mask = 8'h3F;
      5:       keep_mask = 8'h1F;
      6:       keep_mask = 8'hFF;
      7:       keep_mask = 8'hB3;
      default: keep_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ptr.sv
module rtc_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic          wrap
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_addr;
    else if (adv)  ptr <= ptr + 1'b1;
  end

  assign wrap = adv && !load && (ptr == {AW{1'b1}});
endmodule

// File: rtl/rtc_snap.sv
module rtc_snap
  import rtc_regfile_pkg::*;
#(
  parameter int NB = TIME_BYTES,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [NB*8-1:0] live,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_q,
  output logic [NB*8-1:0] snap_flat
);
  logic [7:0] snap [NB];

  for (genvar i = 0; i < NB; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        snap[i] <= '0;
      else if (wr_en && (wr_idx == IW'(i)))
        snap[i] <= wr_data & keep_mask(i);
      else if (capture)
        snap[i] <= live[8*i +: 8] & keep_mask(i);
    end
    assign snap_flat[8*i +: 8] = snap[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= snap[rd_idx];
  end
endmodule

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int DEPTH = 56,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] raddr,
  output logic [7:0]    rq
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rq <= mem[raddr];
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
#(
  parameter int NT = TIME_BYTES,
  parameter int NR = RAM_BYTES,
  localparam int AW  = $clog2(NT + NR),
  localparam int TIW = $clog2(NT),
  localparam int RIW = $clog2(NR)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_start,
  input  logic            bus_stop,
  input  logic            ptr_load,
  input  logic [AW-1:0]   ptr_addr,
  input  logic            wr_ack,
  input  logic [7:0]      wr_data,
  input  logic            rd_ack,
  output logic [7:0]      rd_data,
  input  logic [NT*8-1:0] live_time,
  output logic            tk_we,
  output logic [TIW-1:0]  tk_addr,
  output logic [7:0]      tk_data
);
  logic [AW-1:0]   ptr;
  logic            wrap;
  logic            in_time;
  logic            wr_time, wr_ram;
  logic [RIW-1:0]  ram_idx;
  logic [7:0]      snap_q, ram_q;
  logic            sel_time_q;
  logic [NT*8-1:0] snap_flat;

  rtc_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_addr(ptr_addr),
    .adv(wr_ack | rd_ack), .ptr(ptr), .wrap(wrap)
  );

  assign in_time = (ptr < AW'(NT));
  assign wr_time = wr_ack && in_time;
  assign wr_ram  = wr_ack && !in_time;
  assign ram_idx = in_time ? '0 : RIW'(ptr - AW'(NT));

  rtc_snap #(.NB(NT)) u_snap (
    .clk(clk), .rst(rst), .capture(bus_start | bus_stop | wrap),
    .live(live_time), .wr_en(wr_time), .wr_idx(ptr[TIW-1:0]),
    .wr_data(wr_data), .rd_idx(ptr[TIW-1:0]), .rd_q(snap_q),
    .snap_flat(snap_flat)
  );

  rtc_ram #(.DEPTH(NR)) u_ram (
    .clk(clk), .we(wr_ram), .waddr(ram_idx), .wdata(wr_data),
    .raddr(ram_idx), .rq(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tk_we      <= 1'b0;
      tk_addr    <= '0;
      tk_data    <= '0;
      sel_time_q <= 1'b1;
    end else begin
      tk_we      <= wr_time;
      sel_time_q <= in_time;
      if (wr_time) begin
        tk_addr <= ptr[TIW-1:0];
        tk_data <= wr_data & keep_mask(int'(ptr[TIW-1:0]));
      end
    end
  end

  assign rd_data = sel_time_q ? snap_q : ram_q;
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk
  import rtc_regfile_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        bus_stop,
  input logic        ptr_load,
  input logic [5:0]  ptr_addr,
  input logic        wr_ack,
  input logic        rd_ack,
  input logic [63:0] live_time,
  input logic [5:0]  ptr,
  input logic [63:0] snap_flat,
  input logic        tk_we,
  input logic [2:0]  tk_addr,
  input logic [7:0]  tk_data
);
  logic [63:0] live_masked;
  always_comb
    for (int i = 0; i < 8; i++)
      live_masked[8*i +: 8] = live_time[8*i +: 8] & keep_mask(i);

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
    ptr_load |=> ptr == $past(ptr_addr));

  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (!ptr_load && (wr_ack || rd_ack)) |=> ptr == $past(ptr) + 6'd1);

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ptr_load && !wr_ack && !rd_ack) |=> $stable(ptr));

  assert_stop_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_stop && !wr_ack) |=> snap_flat == $past(live_masked));

  assert_tk_source_R6: assert property (@(posedge clk) disable iff (rst)
    tk_we |-> $past(wr_ack && (ptr < 6'd8)));

  assert_tk_zero_bits_R7: assert property (@(posedge clk) disable iff (rst)
    tk_we |-> ((tk_data & ~keep_mask(int'(tk_addr))) == 8'h00));
endmodule

bind rtc_regfile rtc_regfile_chk u_chk (
  .clk(clk), .rst(rst), .bus_stop(bus_stop), .ptr_load(ptr_load),
  .ptr_addr(ptr_addr), .wr_ack(wr_ack), .rd_ack(rd_ack),
  .live_time(live_time), .ptr(ptr), .snap_flat(snap_flat),
  .tk_we(tk_we), .tk_addr(tk_addr), .tk_data(tk_data)
);

// File: tb/sim_rtc_regfile.sv
`timescale 1ns/1ps
module sim_rtc_regfile;
  logic        clk = 0, rst = 1;
  logic        bus_start = 0, bus_stop = 0, ptr_load = 0, wr_ack = 0, rd_ack = 0;
  logic [5:0]  ptr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [63:0] live_time = 0;
  logic [7:0]  rd_data, tk_data;
  logic        tk_we;
  logic [2:0]  tk_addr;
  int checks = 0, errors = 0;

  rtc_regfile u0 (.*);

  always #2.5 clk = ~clk;

  function automatic logic [7:0] m(input int i);
    logic [7:0] t [8] = '{8'hFF, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF, 8'hB3};
    return t[i];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [5:0] a);
    ptr_load = 1; ptr_addr = a; @(negedge clk); ptr_load = 0; @(negedge clk);
  endtask

  task automatic rd_next();
    rd_ack = 1; @(negedge clk); rd_ack = 0; @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_ack = 1; wr_data = d; @(negedge clk); wr_ack = 0;
  endtask

  task automatic pulse_start();
    bus_start = 1; @(negedge clk); bus_start = 0;
  endtask

  task automatic pulse_stop();
    bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 tk_we", {7'd0, tk_we}, 8'h00);
    load(6'd5);
    chk("R1 shadow zero", rd_data, 8'h00);
  endtask

  task automatic t_ram();
    load(6'd8);
    wr(8'hA5); chk("R8 no tk_we", {7'd0, tk_we}, 8'h00);
    wr(8'hFF); wr(8'h3C);
    load(6'd8);  chk("R8 ram 08", rd_data, 8'hA5);
    rd_next();   chk("R3 R8 ram 09", rd_data, 8'hFF);
    rd_next();   chk("R8 ram 0A", rd_data, 8'h3C);
    load(6'd10); rd_next(); rd_next(); rd_next();
    load(6'd13); wr(8'h77);
    load(6'd10); rd_next(); rd_next(); rd_next();
    chk("R3 advance by acks", rd_data, 8'h77);
  endtask

  task automatic t_start_capture();
    logic [63:0] l1 = 64'h93_99_12_31_FD_23_D9_45;
    live_time = l1;
    pulse_start();
    live_time = 64'hFF_FF_FF_FF_FF_FF_FF_FF;
    load(6'd0);
    for (int i = 0; i < 8; i++) begin
      chk("R4 R5 R7 start snapshot", rd_data, l1[8*i +: 8] & m(i));
      if (i < 7) rd_next();
    end
    load(6'd8);
    chk("R8 ram not captured", rd_data, 8'hA5);
  endtask

  task automatic t_stop_capture();
    live_time = 64'h01_02_03_04_05_06_07_58;
    pulse_stop();
    live_time = 64'h0;
    load(6'd0);
    chk("R4 stop snapshot b0", rd_data, 8'h58);
    load(6'd7);
    chk("R4 R7 stop snapshot b7", rd_data, 8'h01);
  endtask

  task automatic t_wrap();
    load(6'h3F); wr(8'hC3);
    load(6'h3F);
    chk("R8 ram 3F", rd_data, 8'hC3);
    live_time = 64'h00_00_00_00_00_00_00_37;
    rd_next();
    chk("R3 R4 wrap snapshot", rd_data, 8'h37);
    live_time = 64'h00_00_00_00_00_00_00_11;
    rd_next();
    chk("R5 no live leak", rd_data, 8'h00);
  endtask

  task automatic t_write_time();
    load(6'd2);
    wr(8'hFF);
    chk("R6 tk_we", {7'd0, tk_we}, 8'h01);
    chk("R6 tk_addr", {5'd0, tk_addr}, 8'h02);
    chk("R6 R7 tk_data", tk_data, 8'h7F);
    @(negedge clk);
    chk("R6 tk_we one cycle", {7'd0, tk_we}, 8'h00);
    load(6'd2);
    chk("R6 R7 buffer updated", rd_data, 8'h7F);
  endtask

  task automatic t_write_vs_capture();
    live_time = 64'h00_00_1C_2A_00_00_00_00;
    load(6'd4);
    wr_ack = 1; wr_data = 8'h12; bus_start = 1;
    @(negedge clk); wr_ack = 0; bus_start = 0;
    live_time = 0;
    load(6'd4);
    chk("R9 write wins", rd_data, 8'h12);
    rd_next();
    chk("R9 others captured", rd_data, 8'h1C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_ram();
    t_start_capture();
    t_stop_capture();
    t_wrap();
    t_write_time();
    t_write_vs_capture();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule